// File: doc/BRIEF.md
# Evicted-Address Reuse Predictor

This block keeps a compact record of the cache blocks that were recently evicted and uses it to guess whether a block that has just missed is likely to be reused. Each eviction writes the evicted block address into a single-bit-per-entry membership filter, addressed by two different hashes of the address. When a miss comes in, the missed address is looked up in the same filter. If both hashed bits are set, the verdict is high reuse and the cache controller should insert the block with high priority. Otherwise the verdict is low reuse, and the block should go in with low priority. The filter can report false positives, and that is acceptable here.

Entries are never removed one by one. The whole filter is wiped when an insertion counter reaches its limit. This caps how many misses in a row can be called high reuse, which stops a large working set from thrashing the cache. There is an optional decoupled mode with a second counter, which counts misses that were predicted high reuse. When either counter reaches its limit, the filter and both counters are cleared. Each verdict is registered and comes back one cycle after its request, flagged by a valid strobe.

Top module: `evict_reuse_predictor`

## Requirements
- R1: After a synchronous reset, `rsp_valid` is 0, the filter is empty and both counters are zero, so the first test of any address returns low reuse.
- R2: A test request on `tst_valid` produces exactly one response: `rsp_valid` is 1 in the following cycle and 0 in any cycle whose preceding cycle had no request.
- R3: The filter holds FILT_BITS bits, where FILT_BITS = CACHE_BLOCKS*BITS_PER_ADDR (512 by default) and IDX_W = log2(FILT_BITS). Two hashes each produce one bit index:
  - The direct hash XORs address bit i into index bit (i mod IDX_W).
  - The mirrored hash XORs address bit i into index bit ((ADDR_W-1-i) mod IDX_W).
  
  A test returns `rsp_reuse`=1 only when both indexed bits are set.
- R4: An eviction that does not coincide with a clear sets both hashed bits of its address. A later test of that address therefore returns high reuse until the next clear.
- R5: A positive test removes nothing. Repeated tests of a present address keep returning high reuse.
- R6: The insertion counter counts accepted evictions. The eviction that would bring the counter to CNT_MAX (CACHE_BLOCKS by default) instead clears every filter bit and both counters. That eviction is not recorded.
- R7: When an eviction and a test of the same address arrive in the same cycle, the test sees the filter as it was before the insert.
- R8: With DECOUPLED=1, a second counter counts tests that return high reuse. The test that would bring this counter to HR_MAX (CACHE_BLOCKS by default) clears the filter and both counters. A clear always wins over a same-cycle eviction.
- R9: `rsp_reuse` is 0 whenever `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_valid | input | 1 | An eviction is presented this cycle |
| ev_addr | input | ADDR_W | Block address of the evicted line |
| tst_valid | input | 1 | A missed block is presented for prediction |
| tst_addr | input | ADDR_W | Block address of the missed line |
| rsp_valid | output | 1 | Verdict strobe, one cycle after a test |
| rsp_reuse | output | 1 | 1 = high reuse, 0 = low reuse |

## Verification
Random traffic draws addresses from a small pool, so tests of recently evicted addresses hit while tests of other pool members mostly miss. This separates correct hash and membership logic from a filter that is stuck high or stuck low. Directed sequences cover several cases:
- a same-cycle eviction and test of one address, which separates the pre-insert view from an insert bypass;
- a run of exactly CNT_MAX evictions, which exposes an off-by-one counter limit;
- a long run of hits on one address, which drives the decoupled counter to its limit.

A default instance and a decoupled instance run side by side on the same stimulus, so a clear that fires in the wrong mode shows up as a mismatch between them.

// File: rtl/erp_pkg.sv
package erp_pkg;

   typedef enum logic {
      HASH_DIRECT = 1'b0,
      HASH_MIRROR = 1'b1
   } erp_hash_e;

   function automatic bit erp_is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/erp_hash.sv
module erp_hash
   import erp_pkg::*;
#(
   parameter int        ADDR_W  = 32,
   parameter int        IDX_W   = 9,
   parameter erp_hash_e VARIANT = HASH_DIRECT
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [IDX_W-1:0]  idx
);
   localparam int NCHUNK = (ADDR_W + IDX_W - 1) / IDX_W;
   localparam int PAD_W  = NCHUNK * IDX_W;

   logic [ADDR_W-1:0] src;
   logic [PAD_W-1:0]  padded;

   generate
      if (VARIANT == HASH_MIRROR) begin : g_mirror
         always_comb begin
            for (int i = 0; i < ADDR_W; i++) src[i] = addr[ADDR_W-1-i];
         end
      end else begin : g_direct
         assign src = addr;
      end
   endgenerate

   assign padded = PAD_W'(src);

   always_comb begin
      idx = '0;
      for (int c = 0; c < NCHUNK; c++) idx ^= padded[c*IDX_W +: IDX_W];
   end
endmodule

// File: rtl/erp_bitvec.sv
module erp_bitvec #(
   parameter int FILT_BITS = 512,
   parameter int IDX_W     = 9
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic             ins,
   input  logic [IDX_W-1:0] ins_a,
   input  logic [IDX_W-1:0] ins_b,
   input  logic [IDX_W-1:0] tst_a,
   input  logic [IDX_W-1:0] tst_b,
   output logic             present
);
   logic [FILT_BITS-1:0] vec;

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         vec <= '0;
      end else if (ins) begin
         vec[ins_a] <= 1'b1;
         vec[ins_b] <= 1'b1;
      end
   end

   assign present = vec[tst_a] & vec[tst_b];

   AST_INSERT_SETS: assert property (@(posedge clk) disable iff (rst)
      (ins && !clr) |=> (vec[$past(ins_a)] && vec[$past(ins_b)])); // R4
   AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (rst)
      clr |=> (vec == '0)); // R6
   AST_NO_REMOVE: assert property (@(posedge clk) disable iff (rst)
      !clr |=> ((vec & $past(vec)) == $past(vec))); // R5
endmodule

// File: rtl/erp_clear_ctrl.sv
module erp_clear_ctrl #(
   parameter int CNT_MAX   = 64,
   parameter int HR_MAX    = 64,
   parameter bit DECOUPLED = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic ev_valid,
   input  logic hr_hit,
   output logic clr
);
   localparam int CNT_W = $clog2(CNT_MAX + 1);
   localparam int HR_W  = $clog2(HR_MAX + 1);

   logic [CNT_W-1:0] ins_cnt;
   logic [HR_W-1:0]  hr_cnt;
   logic             clr_ins;
   logic             clr_hr;

   assign clr_ins = ev_valid && (ins_cnt == CNT_W'(CNT_MAX - 1));
   assign clr_hr  = hr_hit && (hr_cnt == HR_W'(HR_MAX - 1));

   generate
      if (DECOUPLED) begin : g_dual
         assign clr = clr_ins | clr_hr;
      end else begin : g_single
         assign clr = clr_ins;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || clr) ins_cnt <= '0;
      else if (ev_valid) ins_cnt <= ins_cnt + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst || clr) hr_cnt <= '0;
      else if (hr_hit && DECOUPLED) hr_cnt <= hr_cnt + 1'b1;
   end

   AST_INS_BOUND: assert property (@(posedge clk) disable iff (rst)
      ins_cnt < CNT_W'(CNT_MAX)); // R6
   AST_HR_BOUND: assert property (@(posedge clk) disable iff (rst)
      hr_cnt < HR_W'(HR_MAX)); // R8
   AST_CLEAR_RESETS: assert property (@(posedge clk) disable iff (rst)
      clr |=> (ins_cnt == '0 && hr_cnt == '0)); // R6
endmodule

// File: rtl/evict_reuse_predictor.sv
module evict_reuse_predictor
   import erp_pkg::*;
#(
   parameter int ADDR_W        = 32,
   parameter int CACHE_BLOCKS  = 64,
   parameter int BITS_PER_ADDR = 8,
   parameter int CNT_MAX       = CACHE_BLOCKS,
   parameter int HR_MAX        = CACHE_BLOCKS,
   parameter bit DECOUPLED     = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ev_valid,
   input  logic [ADDR_W-1:0] ev_addr,
   input  logic              tst_valid,
   input  logic [ADDR_W-1:0] tst_addr,
   output logic              rsp_valid,
   output logic              rsp_reuse
);
   localparam int FILT_BITS = CACHE_BLOCKS * BITS_PER_ADDR;
   localparam int IDX_W     = $clog2(FILT_BITS);

   generate
      if (!erp_is_pow2(FILT_BITS)) begin : g_bad_size
         $error("filter size must be a power of two");
      end
      if (CNT_MAX < 2 || HR_MAX < 2) begin : g_bad_limit
         $error("clear limits must be at least 2");
      end
   endgenerate

   logic [IDX_W-1:0] ev_idx  [2];
   logic [IDX_W-1:0] tst_idx [2];
   logic             present;
   logic             clr;
   logic             hr_hit;

   generate
      for (genvar g = 0; g < 2; g++) begin : g_hash
         localparam erp_hash_e V = (g == 0) ? HASH_DIRECT : HASH_MIRROR;
         erp_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .VARIANT(V)) i_ev_hash (
            .addr(ev_addr), .idx(ev_idx[g]));
         erp_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .VARIANT(V)) i_tst_hash (
            .addr(tst_addr), .idx(tst_idx[g]));
      end
   endgenerate

   erp_bitvec #(.FILT_BITS(FILT_BITS), .IDX_W(IDX_W)) i_bitvec (
      .clk(clk), .rst(rst), .clr(clr), .ins(ev_valid),
      .ins_a(ev_idx[0]), .ins_b(ev_idx[1]),
      .tst_a(tst_idx[0]), .tst_b(tst_idx[1]),
      .present(present));

   assign hr_hit = tst_valid & present;

   erp_clear_ctrl #(.CNT_MAX(CNT_MAX), .HR_MAX(HR_MAX), .DECOUPLED(DECOUPLED)) i_clear (
      .clk(clk), .rst(rst), .ev_valid(ev_valid), .hr_hit(hr_hit), .clr(clr));

   always_ff @(posedge clk) begin
      if (rst) begin
         rsp_valid <= 1'b0;
         rsp_reuse <= 1'b0;
      end else begin
         rsp_valid <= tst_valid;
         rsp_reuse <= hr_hit;
      end
   end

   AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      tst_valid |=> rsp_valid); // R2
   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
      !tst_valid |=> !rsp_valid); // R2
   AST_REUSE_QUAL: assert property (@(posedge clk) disable iff (rst)
      !rsp_valid |-> !rsp_reuse); // R9
endmodule

// File: tb/test_evict_reuse_predictor.sv
module test_evict_reuse_predictor;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 32;
   localparam int BLOCKS     = 64;
   localparam int FILT       = BLOCKS * 8;
   localparam int IDXW       = 9;
   localparam int CMAX       = BLOCKS;
   localparam int HMAX       = BLOCKS;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic ev_valid = 1'b0, tst_valid = 1'b0;
   logic [ADDR_W-1:0] ev_addr = '0, tst_addr = '0;
   logic rv0, rr0, rv1, rr1;

   int checks = 0, errors = 0;
   logic [FILT-1:0] mvec [2];
   int mins [2];
   int mhr  [2];
   bit exp_v [2];
   bit exp_r [2];

   always #(CLK_PERIOD/2) clk = ~clk;

   evict_reuse_predictor i_evict_reuse_predictor (
      .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_addr(ev_addr),
      .tst_valid(tst_valid), .tst_addr(tst_addr), .rsp_valid(rv0), .rsp_reuse(rr0));

   evict_reuse_predictor #(.DECOUPLED(1'b1)) i_evict_reuse_predictor_dc (
      .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_addr(ev_addr),
      .tst_valid(tst_valid), .tst_addr(tst_addr), .rsp_valid(rv1), .rsp_reuse(rr1));

   function automatic int hsh(input logic [ADDR_W-1:0] a, input bit mirror);
      logic [IDXW-1:0] acc = '0;
      for (int i = 0; i < ADDR_W; i++) begin
         int pos = mirror ? (ADDR_W - 1 - i) % IDXW : i % IDXW;
         acc[pos] ^= a[i];
      end
      return int'(acc);
   endfunction

   task automatic model_reset();
      for (int m = 0; m < 2; m++) begin
         mvec[m] = '0; mins[m] = 0; mhr[m] = 0; exp_v[m] = 0; exp_r[m] = 0;
      end
   endtask

   task automatic check(input bit act, input bit exp, input string tag, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
      end
   endtask

   task automatic cycle(input bit ev, input logic [ADDR_W-1:0] ea,
                        input bit tv, input logic [ADDR_W-1:0] ta, input string tag);
      ev_valid = ev; ev_addr = ea; tst_valid = tv; tst_addr = ta;
      for (int m = 0; m < 2; m++) begin
         bit hit = tv && mvec[m][hsh(ta, 0)] && mvec[m][hsh(ta, 1)];
         bit clr = (ev && mins[m] == CMAX - 1) || (m == 1 && hit && mhr[m] == HMAX - 1);
         exp_v[m] = tv; exp_r[m] = hit;
         if (clr) begin
            mvec[m] = '0; mins[m] = 0; mhr[m] = 0;
         end else begin
            if (ev) begin
               mvec[m][hsh(ea, 0)] = 1'b1; mvec[m][hsh(ea, 1)] = 1'b1; mins[m]++;
            end
            if (m == 1 && hit) mhr[m]++;
         end
      end
      @(negedge clk);
      check(rv0, exp_v[0], "R2", "valid");
      check(rv1, exp_v[1], "R2", "valid dc");
      check(rr0, exp_r[0], tag, "reuse");
      check(rr1, exp_r[1], tag, "reuse dc");
      if (!rv0) check(rr0, 1'b0, "R9", "reuse without valid");
   endtask

   task automatic do_reset();
      rst = 1'b1; ev_valid = 0; tst_valid = 0;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      model_reset();
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 200000);
      errors++; checks++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : stim
      logic [ADDR_W-1:0] pool [16];
      void'($urandom(32'd7));
      for (int i = 0; i < 16; i++) pool[i] = $urandom;
      @(negedge clk);
      do_reset();
      check(rv0, 1'b0, "R1", "valid after reset");
      cycle(0, '0, 1, 32'h1234_5678, "R1");
      // R3/R4: evict then test
      cycle(1, 32'hA5A5_0040, 0, '0, "R4");
      cycle(0, '0, 1, 32'hA5A5_0040, "R4");
      cycle(0, '0, 1, 32'h0000_0001, "R3");
      // R5: repeated positive tests stay positive
      cycle(0, '0, 1, 32'hA5A5_0040, "R5");
      cycle(0, '0, 1, 32'hA5A5_0040, "R5");
      // R7: same-cycle evict and test of one address
      cycle(1, 32'h0BAD_C0DE, 1, 32'h0BAD_C0DE, "R7");
      cycle(0, '0, 1, 32'h0BAD_C0DE, "R7");
      // R6: CNT_MAX-th eviction clears
      do_reset();
      for (int i = 0; i < CMAX - 1; i++) cycle(1, 32'h100 + 32'(i * 64), 0, '0, "R6");
      cycle(0, '0, 1, 32'h100, "R6");
      cycle(1, 32'hFFFF_0000, 0, '0, "R6");
      cycle(0, '0, 1, 32'h100, "R6");
      cycle(0, '0, 1, 32'hFFFF_0000, "R6");
      // R8: decoupled instance clears after HR_MAX positive tests
      do_reset();
      cycle(1, 32'hCAFE_0000, 0, '0, "R8");
      for (int i = 0; i < HMAX; i++) cycle(0, '0, 1, 32'hCAFE_0000, "R8");
      cycle(0, '0, 1, 32'hCAFE_0000, "R8");
      // random traffic
      do_reset();
      for (int i = 0; i < 4000; i++) begin
         bit ev = ($urandom % 3) == 0;
         bit tv = ($urandom % 2) == 0;
         cycle(ev, pool[$urandom % 16], tv, pool[$urandom % 16], "R3");
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule